// File: doc/BRIEF.md
# Shared Timer Prescaler with Per-Channel Clock Select

This block supplies the count timing for two timer channels from one free-running prescaler. A 10-bit counter advances on every system clock cycle. Four tap strobes come from its low bits, giving rates of one eighth, one sixty-fourth, one two-hundred-fifty-sixth and one thousand-twenty-fourth of the system clock. Each channel has its own 3-bit source select. From that select, the channel produces a registered, single-cycle count-enable pulse taken from one of these sources:

- every system clock cycle;
- one of the four taps;
- a rising or falling external edge pulse that an outside synchronizer has already produced.

The channel select has no effect on the prescaler. Because of that, the first count after a channel starts using a tap can come at any phase of the divisor. Software can assert the prescaler clear to align the taps with program execution. Both channels see that clear.

Top module: `shared_psc_sel`

## Requirements
- R1: While rst_n is low, cnt_en is 0 on every channel, and the prescaler is held at zero.
- R2: The prescaler advances by one every cycle and wraps from 1023 to 0. The select values of the channels never alter its phase.
- R3: Select 0 stops the channel. cnt_en stays 0 whatever the tap strobes or the external edge inputs do.
- R4: Select 1 makes cnt_en 1 in every cycle that follows a cycle in which select 1 was applied.
- R5: Select 2, 3, 4 and 5 choose divide-by-8, 64, 256 and 1024. cnt_en is 1 in the cycle after the low 3, 6, 8 or 10 prescaler bits are all ones, so it is 1 for exactly one cycle in every N.
- R6: Select 6 copies ext_fall and select 7 copies ext_rise onto cnt_en one cycle later. With select 6, ext_rise has no effect, and with select 7, ext_fall has no effect.
- R7: psc_clr makes the prescaler zero on the next cycle and suppresses the tap strobes in the cycle it is asserted. A divide-by-N channel then pulses exactly N cycles after the prescaler reads zero.
- R8: Each channel follows its own select field, chan_sel[3*c+2:3*c]. The two channels may use different sources at the same time.
- R9: When a channel switches from select 0 to a tap with divisor N, its first pulse comes between 1 and N+1 cycles after the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psc_clr | input | 1 | Clears the shared prescaler |
| chan_sel | input | 6 | Source select for each channel, 3 bits per channel |
| ext_rise | input | 2 | Synchronized rising-edge pulse, one per channel |
| ext_fall | input | 2 | Synchronized falling-edge pulse, one per channel |
| cnt_en | output | 2 | Registered count-enable pulse, one per channel |

## Verification
On every cycle, the assertions check four things: that the prescaler steps or clears, that select 0 and select 1 force cnt_en low or high, that the edge sources copy their pulse one cycle later, and that a tap source never pulses without its strobe. Some behaviour only the bench scenarios can show. These are the exact pulse spacing of each divisor, the independence of the two channels while the other one switches, the alignment after a clear, and the spread of the first-count latency. The bench shows them by comparing cnt_en on every cycle with a separate model of the prescaler phase.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [2:0] {
    SRC_OFF   = 3'd0,
    SRC_SYS   = 3'd1,
    SRC_D8    = 3'd2,
    SRC_D64   = 3'd3,
    SRC_D256  = 3'd4,
    SRC_D1024 = 3'd5,
    SRC_FALL  = 3'd6,
    SRC_RISE  = 3'd7
  } src_sel_e;

  localparam int NTAP  = 4;
  localparam int SEL_W = 3;

  // Number of low prescaler bits that a tap watches.
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // Tap index for a prescaled select value (2..5 map to 0..3).
  function automatic logic [1:0] tap_index(input logic [SEL_W-1:0] s);
    return 2'(s - 3'd2);
  endfunction
endpackage

// File: rtl/tps_prescaler.sv
module tps_prescaler
  import tps_pkg::*;
#(
  parameter int NT = NTAP,
  localparam int W = tap_shift(NT - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [NT-1:0] tap_stb,
  output logic [W-1:0]  psc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) psc_q <= '0;
    else               psc_q <= psc_q + 1'b1;
  end

  // A strobe fires when its low bits are about to wrap to zero.
  for (genvar t = 0; t < NT; t++) begin : g_tap
    localparam int SH = tap_shift(t);
    assign tap_stb[t] = (&psc_q[SH-1:0]) & ~clr;
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (psc_q == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (psc_q == $past(psc_q) + 1'b1));
endmodule

// File: rtl/tps_chan_sel.sv
module tps_chan_sel
  import tps_pkg::*;
#(
  parameter int NT = NTAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [NT-1:0]    tap_stb,
  input  logic             ext_rise,
  input  logic             ext_fall,
  output logic             cnt_en
);
  logic pick;
  logic tap_hit;

  assign tap_hit = tap_stb[tap_index(sel)];

  always_comb begin
    case (src_sel_e'(sel))
      SRC_OFF:  pick = 1'b0;
      SRC_SYS:  pick = 1'b1;
      SRC_FALL: pick = ext_fall;
      SRC_RISE: pick = ext_rise;
      default:  pick = tap_hit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_en <= 1'b0;
    else        cnt_en <= pick;
  end

  assert_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_OFF) |=> !cnt_en);
  assert_sys_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_SYS) |=> cnt_en);
  assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_RISE) |=> (cnt_en == $past(ext_rise)));
  assert_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_FALL) |=> (cnt_en == $past(ext_fall)));
  assert_tap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SRC_D8 && sel <= SRC_D1024 && !tap_stb[tap_index(sel)]) |=> !cnt_en);
endmodule

// File: rtl/shared_psc_sel.sv
module shared_psc_sel
  import tps_pkg::*;
#(
  parameter int NCH = 2,
  localparam int PW = tap_shift(NTAP - 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psc_clr,
  input  logic [NCH*SEL_W-1:0] chan_sel,
  input  logic [NCH-1:0]       ext_rise,
  input  logic [NCH-1:0]       ext_fall,
  output logic [NCH-1:0]       cnt_en
);
  logic [NTAP-1:0] tap_stb;
  logic [PW-1:0]   psc_q;

  tps_prescaler #(.NT(NTAP)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (psc_clr),
    .tap_stb (tap_stb),
    .psc_q   (psc_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tps_chan_sel #(.NT(NTAP)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (chan_sel[c*SEL_W +: SEL_W]),
      .tap_stb  (tap_stb),
      .ext_rise (ext_rise[c]),
      .ext_fall (ext_fall[c]),
      .cnt_en   (cnt_en[c])
    );
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (cnt_en == '0 && psc_q == '0));
endmodule

// File: tb/shared_psc_sel_bench.sv
`timescale 1ns/1ps
module shared_psc_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       psc_clr;
  logic [5:0] chan_sel;
  logic [1:0] ext_rise, ext_fall;
  logic [1:0] cnt_en;

  int checks = 0;
  int errors = 0;
  int m = 0;     // modelled prescaler phase
  bit done = 0;

  always #4 clk = ~clk;

  shared_psc_sel u_shared_psc_sel (
    .clk(clk), .rst_n(rst_n), .psc_clr(psc_clr), .chan_sel(chan_sel),
    .ext_rise(ext_rise), .ext_fall(ext_fall), .cnt_en(cnt_en)
  );

  typedef struct packed {
    logic [2:0]  s0;
    logic [2:0]  s1;
    logic        clr;
    logic        r0, f0, r1, f1;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd20},   // R4 R5
    '{3'd3, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd300},  // R5 R8
    '{3'd5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1100}, // R5 R2
    '{3'd7, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd3},    // R6
    '{3'd7, 3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd3},    // R6 ignored edge
    '{3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'd4},    // R3
    '{3'd2, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2},    // R7
    '{3'd4, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd600},  // R5 R7
    '{3'd6, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd5},    // R6 R4 R8
    '{3'd0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd30}    // R3 R8
  };

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0:    return "R3";
      3'd1:    return "R4";
      3'd6,
      3'd7:    return "R6";
      default: return "R5";
    endcase
  endfunction

  // Expected next enable from the requirement text.
  function automatic logic predict(input logic [2:0] s, input int ph, input logic clr,
                                   input logic r, input logic f);
    int div;
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd6: return f;
      3'd7: return r;
      default: begin
        div = (s == 3'd2) ? 8 : (s == 3'd3) ? 64 : (s == 3'd4) ? 256 : 1024;
        return !clr && ((ph % div) == div - 1);
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock step with per-cycle prediction of both channels.
  task automatic tick();
    logic e0, e1;
    e0 = predict(chan_sel[2:0], m, psc_clr, ext_rise[0], ext_fall[0]);
    e1 = predict(chan_sel[5:3], m, psc_clr, ext_rise[1], ext_fall[1]);
    m = psc_clr ? 0 : (m + 1) % 1024;
    @(posedge clk);
    @(negedge clk);
    check(cnt_en[0] == e0, req_of(chan_sel[2:0]), int'(cnt_en[0]), int'(e0));
    check(cnt_en[1] == e1, {req_of(chan_sel[5:3]), " R8"}, int'(cnt_en[1]), int'(e1));
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    rst_n = 1'b0; psc_clr = 1'b0; chan_sel = {3'd1, 3'd1};
    ext_rise = 2'b11; ext_fall = 2'b11;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check(cnt_en == 2'b00, "R1", int'(cnt_en), 0);   // R1 reset state
    end
    m = 0;
    rst_n = 1'b1;
    ext_rise = '0; ext_fall = '0; chan_sel = '0;

    // Vector table
    foreach (VECS[i]) begin
      chan_sel = {VECS[i].s1, VECS[i].s0};
      psc_clr  = VECS[i].clr;
      ext_rise = {VECS[i].r1, VECS[i].r0};
      ext_fall = {VECS[i].f1, VECS[i].f0};
      for (int k = 0; k < int'(VECS[i].n); k++) tick();
    end
    psc_clr = 1'b0; ext_rise = '0; ext_fall = '0;

    // R7: clear then divide-by-8 pulses exactly 8 cycles after zero
    chan_sel = {3'd0, 3'd2};
    psc_clr = 1'b1; tick(); psc_clr = 1'b0;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      tick(); lat++;
      if (cnt_en[0]) break;
    end
    check(lat == 8, "R7", lat, 8);

    // R9: first count after enabling divide-by-64 at an odd phase
    chan_sel = '0;
    repeat (13) tick();
    chan_sel = {3'd0, 3'd3};
    lat = 0;
    for (int k = 0; k < 70; k++) begin
      tick(); lat++;
      if (cnt_en[0]) break;
    end
    check(lat >= 1 && lat <= 65, "R9", lat, 65);

    // R1: reset mid-run clears the outputs
    chan_sel = {3'd1, 3'd1};
    tick();
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(cnt_en == 2'b00, "R1", int'(cnt_en), 0);
    rst_n = 1'b1; m = 0; chan_sel = {3'd2, 3'd0};
    for (int k = 0; k < 16; k++) tick();   // R1 prescaler restarts at zero

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule